// File: doc/BRIEF.md
# Boot-Block Write Guard

This block sits between the command decoder of a flash-style array and its program/erase engine. It takes a word address and a program or erase request, then decides at once whether that request may go ahead. The address is mapped onto a non-uniform layout. Eight small parameter blocks of 4096 words sit at one end of the map. Large main blocks of 32768 words fill the rest. A build-time parameter puts the parameter group at the top or at the bottom of the map.

For the block that contains the address, the guard reports its index, its lowest word address (which the erase engine sweeps from) and whether it is a parameter block. Two checks are made. First, the two parameter blocks at the outer end of the map are refused while the write-protect pin is low. Second, every program or erase is refused while the programming-supply-good flag is low. For each refusal the guard also produces the set of status-register bits to raise. The logic is purely combinational. The command controller samples its result on the confirm write.

Top module: `bb_protect_chk`

## Requirements
- R1: Eight parameter blocks of 4096 words lie in the highest 32768 words of the map when TOP_BOOT=1, and in the lowest 32768 words when TOP_BOOT=0. `is_param_o` is high exactly for addresses inside them.
- R2: Every other address lies in a main block of 32768 words. There are (ARRAY_WORDS-32768)/32768 main blocks, which is 31 at the default of 1M words.
- R3: `blk_idx_o` numbers the blocks from 0 at the lowest address upward, one per block, so the highest block is 38 at the default size.
- R4: `blk_base_o` is the lowest word address of the block that holds `addr_i`.
- R5: With `wp_ni` low, a request aimed at one of the two outermost parameter blocks (the two highest blocks for top boot, the two lowest for bottom boot) raises `lock_fail_o` and holds `grant_o` low.
- R6: With `wp_ni` high, no request raises `lock_fail_o`. The other six parameter blocks and all main blocks never raise it, whatever the level of `wp_ni`.
- R7: With `vpp_ok_i` low, any request raises `vpp_fail_o` and holds `grant_o` low. Both fail flags may be high together.
- R8: `sr_set_o` sets bit 1 on a lock fail and bit 3 on a supply fail. It also sets bit 4 on any refused program and bit 5 on any refused erase. All other bits are 0.
- R9: `op_i` = 2'b01 requests a program and 2'b10 requests an erase. Codes 2'b00 and 2'b11 carry no request and force `grant_o`, both fail flags and `sr_set_o` to zero.
- R10: `grant_o` is high exactly when a request is present and neither fail flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | AW (20) | Word address of the request |
| op_i | input | 2 | Request type: 01 program, 10 erase, otherwise none |
| wp_ni | input | 1 | Write-protect level, low locks the outer parameter blocks |
| vpp_ok_i | input | 1 | Programming supply above lockout level |
| blk_idx_o | output | IW (6) | Index of the addressed block |
| blk_base_o | output | AW (20) | Lowest word address of the addressed block |
| is_param_o | output | 1 | Addressed block is a parameter block |
| lock_fail_o | output | 1 | Request refused because the block is locked |
| vpp_fail_o | output | 1 | Request refused because the supply is low |
| grant_o | output | 1 | Request may proceed |
| sr_set_o | output | 8 | Status-register bits to raise for this request |

## Verification
The hardest situation to reach is the boundary of the parameter group in the top-boot layout. It starts at an offset that is not a power of two (31×32768), so the last main word, the first parameter word and the split between lockable and unlockable parameter blocks are all single addresses. Random addresses rarely hit them. The stimulus therefore walks those exact edge words under every write-protect, supply and operation combination. The same vectors also drive a bottom-boot instance, whose edges fall at different addresses. After that, a long random run compares both instances against a behavioural model on every clock.

// File: rtl/bb_protect_pkg.sv
package bb_protect_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_PROG  = 2'b01,
    OP_ERASE = 2'b10,
    OP_RSVD  = 2'b11
  } op_e;

  localparam int unsigned PARAM_SHIFT = 12;
  localparam int unsigned MAIN_SHIFT  = 15;
  localparam int unsigned PARAM_WORDS = 1 << PARAM_SHIFT;
  localparam int unsigned MAIN_WORDS  = 1 << MAIN_SHIFT;
  localparam int unsigned N_PARAM     = MAIN_WORDS / PARAM_WORDS;
  localparam int unsigned N_LOCKABLE  = 2;

  localparam int unsigned SR_LOCK  = 1;
  localparam int unsigned SR_VPP   = 3;
  localparam int unsigned SR_PFAIL = 4;
  localparam int unsigned SR_EFAIL = 5;
endpackage

// File: rtl/bb_block_map.sv
module bb_block_map
  import bb_protect_pkg::*;
#(
  parameter int unsigned AW       = 20,
  parameter int unsigned IW       = 6,
  parameter int unsigned N_MAIN   = 31,
  parameter bit          TOP_BOOT = 1'b1
) (
  input  logic [AW-1:0] addr_i,
  output logic [IW-1:0] idx_o,
  output logic [AW-1:0] base_o,
  output logic          is_param_o,
  output logic          lockable_o
);
  localparam int unsigned PIW = $clog2(N_PARAM);

  logic [PIW-1:0] pidx;

  generate
    if (TOP_BOOT) begin : g_top
      localparam logic [AW-1:0] BOUND = AW'(N_MAIN * MAIN_WORDS);
      always_comb begin
        is_param_o = (addr_i >= BOUND);
        pidx       = PIW'((addr_i - BOUND) >> PARAM_SHIFT);
        if (is_param_o) begin
          idx_o      = IW'(N_MAIN) + IW'(pidx);
          base_o     = {addr_i[AW-1:PARAM_SHIFT], {PARAM_SHIFT{1'b0}}};
          lockable_o = (pidx >= PIW'(N_PARAM - N_LOCKABLE));
        end else begin
          idx_o      = IW'(addr_i[AW-1:MAIN_SHIFT]);
          base_o     = {addr_i[AW-1:MAIN_SHIFT], {MAIN_SHIFT{1'b0}}};
          lockable_o = 1'b0;
        end
      end
    end else begin : g_bottom
      always_comb begin
        is_param_o = (addr_i[AW-1:MAIN_SHIFT] == '0);
        pidx       = addr_i[MAIN_SHIFT-1:PARAM_SHIFT];
        if (is_param_o) begin
          idx_o      = IW'(pidx);
          base_o     = {addr_i[AW-1:PARAM_SHIFT], {PARAM_SHIFT{1'b0}}};
          lockable_o = (pidx < PIW'(N_LOCKABLE));
        end else begin
          idx_o      = IW'(addr_i[AW-1:MAIN_SHIFT]) + IW'(N_PARAM - 1);
          base_o     = {addr_i[AW-1:MAIN_SHIFT], {MAIN_SHIFT{1'b0}}};
          lockable_o = 1'b0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/bb_guard.sv
module bb_guard
  import bb_protect_pkg::*;
(
  input  logic [1:0] op_i,
  input  logic       lockable_i,
  input  logic       wp_ni,
  input  logic       vpp_ok_i,
  output logic       lock_fail_o,
  output logic       vpp_fail_o,
  output logic       grant_o,
  output logic [7:0] sr_set_o
);
  logic is_prog, is_erase, req, fail;

  always_comb begin
    is_prog     = (op_i == OP_PROG);
    is_erase    = (op_i == OP_ERASE);
    req         = is_prog | is_erase;
    lock_fail_o = req & lockable_i & ~wp_ni;
    vpp_fail_o  = req & ~vpp_ok_i;
    fail        = lock_fail_o | vpp_fail_o;
    grant_o     = req & ~fail;
    sr_set_o           = '0;
    sr_set_o[SR_LOCK]  = lock_fail_o;
    sr_set_o[SR_VPP]   = vpp_fail_o;
    sr_set_o[SR_PFAIL] = fail & is_prog;
    sr_set_o[SR_EFAIL] = fail & is_erase;
  end
endmodule

// File: rtl/bb_protect_chk.sv
module bb_protect_chk
  import bb_protect_pkg::*;
#(
  parameter int unsigned ARRAY_WORDS = 1 << 20,
  parameter bit          TOP_BOOT    = 1'b1,
  localparam int unsigned AW     = $clog2(ARRAY_WORDS),
  localparam int unsigned N_MAIN = (ARRAY_WORDS - MAIN_WORDS) / MAIN_WORDS,
  localparam int unsigned IW     = $clog2(N_MAIN + N_PARAM)
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    op_i,
  input  logic          wp_ni,
  input  logic          vpp_ok_i,
  output logic [IW-1:0] blk_idx_o,
  output logic [AW-1:0] blk_base_o,
  output logic          is_param_o,
  output logic          lock_fail_o,
  output logic          vpp_fail_o,
  output logic          grant_o,
  output logic [7:0]    sr_set_o
);
  logic lockable;

  bb_block_map #(
    .AW(AW), .IW(IW), .N_MAIN(N_MAIN), .TOP_BOOT(TOP_BOOT)
  ) u_map (
    .addr_i    (addr_i),
    .idx_o     (blk_idx_o),
    .base_o    (blk_base_o),
    .is_param_o(is_param_o),
    .lockable_o(lockable)
  );

  bb_guard u_guard (
    .op_i       (op_i),
    .lockable_i (lockable),
    .wp_ni      (wp_ni),
    .vpp_ok_i   (vpp_ok_i),
    .lock_fail_o(lock_fail_o),
    .vpp_fail_o (vpp_fail_o),
    .grant_o    (grant_o),
    .sr_set_o   (sr_set_o)
  );
endmodule

// File: rtl/bb_protect_chk_sva.sv
module bb_protect_chk_sva #(
  parameter int unsigned AW = 20,
  parameter int unsigned IW = 6
) (
  input logic [AW-1:0] addr_i,
  input logic [1:0]    op_i,
  input logic          wp_ni,
  input logic          vpp_ok_i,
  input logic [IW-1:0] blk_idx_o,
  input logic [AW-1:0] blk_base_o,
  input logic          is_param_o,
  input logic          lock_fail_o,
  input logic          vpp_fail_o,
  input logic          grant_o,
  input logic [7:0]    sr_set_o,
  input logic          lockable
);
  logic no_req;
  logic [AW-1:0] span;

  always_comb begin
    no_req = (op_i == 2'b00) || (op_i == 2'b11);
    span   = addr_i - blk_base_o;
    AST_BASE_BELOW_ADDR: assert (blk_base_o <= addr_i); // R4
    AST_BASE_IN_REACH: assert (is_param_o ? (span < AW'(4096)) : (span < AW'(32768))); // R4
    AST_LOCK_ONLY_PARAM: assert (!lock_fail_o || (is_param_o && lockable)); // R6
    AST_LOCK_NEEDS_WP_LOW: assert (!lock_fail_o || !wp_ni); // R6
    AST_VPP_FAIL_BLOCKS: assert (!vpp_fail_o || !grant_o); // R7
    AST_LOCK_FAIL_BLOCKS: assert (!lock_fail_o || !grant_o); // R5
    AST_SR_MATCHES_FLAGS: assert (sr_set_o[1] == lock_fail_o && sr_set_o[3] == vpp_fail_o); // R8
    AST_SR_SPARE_ZERO: assert ((sr_set_o & 8'hC5) == 8'h00); // R8
    AST_IDLE_QUIET: assert (!no_req || (sr_set_o == 8'h00 && !grant_o && !lock_fail_o && !vpp_fail_o)); // R9
    AST_GRANT_OR_REFUSE: assert (no_req || grant_o || lock_fail_o || vpp_fail_o); // R10
  end
endmodule

bind bb_protect_chk bb_protect_chk_sva #(.AW(AW), .IW(IW)) u_sva (
  .addr_i     (addr_i),
  .op_i       (op_i),
  .wp_ni      (wp_ni),
  .vpp_ok_i   (vpp_ok_i),
  .blk_idx_o  (blk_idx_o),
  .blk_base_o (blk_base_o),
  .is_param_o (is_param_o),
  .lock_fail_o(lock_fail_o),
  .vpp_fail_o (vpp_fail_o),
  .grant_o    (grant_o),
  .sr_set_o   (sr_set_o),
  .lockable   (lockable)
);

// File: tb/sim_bb_protect_chk.sv
`timescale 1ns/1ps
module sim_bb_protect_chk;
  localparam int WORDS = 1 << 20;
  localparam int NMAIN = (WORDS - 32768) / 32768;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic [19:0] addr;
  logic [1:0]  op;
  logic        wp_n, vpp_ok;

  logic [5:0]  t_idx, b_idx;
  logic [19:0] t_base, b_base;
  logic        t_par, b_par, t_lf, b_lf, t_vf, b_vf, t_gr, b_gr;
  logic [7:0]  t_sr, b_sr;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  bb_protect_chk #(.ARRAY_WORDS(WORDS), .TOP_BOOT(1'b1)) u0 (
    .addr_i(addr), .op_i(op), .wp_ni(wp_n), .vpp_ok_i(vpp_ok),
    .blk_idx_o(t_idx), .blk_base_o(t_base), .is_param_o(t_par),
    .lock_fail_o(t_lf), .vpp_fail_o(t_vf), .grant_o(t_gr), .sr_set_o(t_sr));

  bb_protect_chk #(.ARRAY_WORDS(WORDS), .TOP_BOOT(1'b0)) u1 (
    .addr_i(addr), .op_i(op), .wp_ni(wp_n), .vpp_ok_i(vpp_ok),
    .blk_idx_o(b_idx), .blk_base_o(b_base), .is_param_o(b_par),
    .lock_fail_o(b_lf), .vpp_fail_o(b_vf), .grant_o(b_gr), .sr_set_o(b_sr));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s addr=%0h op=%0d wp_n=%0b vpp=%0b actual=%0d expected=%0d",
               tag, what, addr, op, wp_n, vpp_ok, act, exp);
    end
  endtask

  // Behavioural model of one layout.
  task automatic model(input bit top, input int a, input int o, input bit wpn, input bit vok,
                       output int idx, output int base, output int par, output int lf,
                       output int vf, output int gr, output int sr);
    int bound, pi;
    bit lockable, req, prog, ers;
    bound = NMAIN * 32768;
    lockable = 1'b0;
    if (top) begin
      if (a >= bound) begin
        par = 1; pi = (a - bound) / 4096; idx = NMAIN + pi;
        base = bound + pi * 4096; lockable = (pi >= 6);
      end else begin
        par = 0; idx = a / 32768; base = idx * 32768;
      end
    end else begin
      if (a < 32768) begin
        par = 1; pi = a / 4096; idx = pi; base = pi * 4096; lockable = (pi < 2);
      end else begin
        par = 0; idx = 8 + (a - 32768) / 32768; base = (a / 32768) * 32768;
      end
    end
    prog = (o == 1); ers = (o == 2); req = prog || ers;
    lf = (req && lockable && !wpn) ? 1 : 0;
    vf = (req && !vok) ? 1 : 0;
    gr = (req && lf == 0 && vf == 0) ? 1 : 0;
    sr = 0;
    if (lf != 0) sr += 2;
    if (vf != 0) sr += 8;
    if ((lf != 0 || vf != 0) && prog) sr += 16;
    if ((lf != 0 || vf != 0) && ers) sr += 32;
  endtask

  task automatic compare_all();
    int idx, base, par, lf, vf, gr, sr;
    model(1'b1, int'(addr), int'(op), wp_n, vpp_ok, idx, base, par, lf, vf, gr, sr);
    chk("R1", "top is_param", int'(t_par), par);
    chk(par != 0 ? "R3" : "R2", "top idx", int'(t_idx), idx);
    chk("R4", "top base", int'(t_base), base);
    chk(wp_n ? "R6" : "R5", "top lock_fail", int'(t_lf), lf);
    chk("R7", "top vpp_fail", int'(t_vf), vf);
    chk((op == 0 || op == 3) ? "R9" : "R10", "top grant", int'(t_gr), gr);
    chk("R8", "top sr_set", int'(t_sr), sr);
    model(1'b0, int'(addr), int'(op), wp_n, vpp_ok, idx, base, par, lf, vf, gr, sr);
    chk("R1", "bot is_param", int'(b_par), par);
    chk(par != 0 ? "R3" : "R2", "bot idx", int'(b_idx), idx);
    chk("R4", "bot base", int'(b_base), base);
    chk(wp_n ? "R6" : "R5", "bot lock_fail", int'(b_lf), lf);
    chk("R7", "bot vpp_fail", int'(b_vf), vf);
    chk((op == 0 || op == 3) ? "R9" : "R10", "bot grant", int'(b_gr), gr);
    chk("R8", "bot sr_set", int'(b_sr), sr);
  endtask

  task automatic apply(input int a, input int o, input bit wpn, input bit vok);
    @(negedge clk);
    addr = 20'(a); op = 2'(o); wp_n = wpn; vpp_ok = vok;
    @(posedge clk);
    #2 compare_all();
  endtask

  int edges [16] = '{0, 4095, 4096, 8191, 8192, 32767, 32768, 65535,
                     1015807, 1015808, 1040383, 1040384, 1044479, 1044480,
                     1048575, 524288};

  initial begin
    addr = '0; op = 2'b00; wp_n = 1'b1; vpp_ok = 1'b1;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    #2;
    // idle state after reset: no request, nothing granted or refused (R9)
    chk("R9", "idle grant", int'(t_gr), 0);
    chk("R9", "idle sr_set", int'(t_sr), 0);
    chk("R3", "idle idx at address 0 top", int'(t_idx), 0);
    chk("R3", "idle idx at address 0 bottom", int'(b_idx), 0);
    // exact block edges under every control combination (R1-R10)
    foreach (edges[i])
      for (int o = 0; o < 4; o++)
        for (int w = 0; w < 2; w++)
          for (int v = 0; v < 2; v++)
            apply(edges[i], o, w[0], v[0]);
    // random sweep
    for (int n = 0; n < 3000; n++)
      apply(int'($urandom_range(WORDS - 1)), int'($urandom_range(3)),
            1'($urandom_range(1)), 1'($urandom_range(1)));
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule